// File: doc/BRIEF.md
# Frame Timestamp Capture Unit

The unit samples a free-running 32-bit local time value at the moment a frame's start-of-frame delimiter passes the transmit or the receive path. It does this for every frame in both directions. Each capture becomes an entry in a small per-path queue. Entries leave through one valid/ready writeback stream, which the descriptor logic uses to fill the timestamp field of that frame's descriptor. An entry carries the 32-bit stamp, a direction bit and one status bit. For a transmit frame the status bit repeats the frame's timestamp-request flag. For a receive frame it is always zero.

A transmit frame that has the request flag set also loads its stamp into a holding register that software can read. The same capture sets a sticky "stamp available" flag. Software waits for that flag, reads the register, and then clears the flag through a write-one-to-clear port. If a second flagged frame arrives while the flag is still set, the holding register is overwritten and a sticky overrun flag is raised.

Back-pressure works as follows. The writeback stream presents an entry while `wb_valid` is high. The entry is consumed on a clock edge where `wb_valid` and `wb_ready` are both high. While `wb_ready` stays low, the presented entry and its fields do not change. Each queue holds `DEPTH` entries. A capture that arrives while its queue is full is lost from the stream only: the holding register path never waits on the stream.

Top module: `frame_stamp_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `wb_valid`, `ts_avail` and `ts_overrun` are 0 and `hold_stamp` is 0.
- R2: On every clock edge with `rx_sof` high, `time_now` is captured as an entry with `wb_is_tx`=0 and `wb_flag`=0.
- R3: On every clock edge with `tx_sof` high, `time_now` is captured as an entry with `wb_is_tx`=1 and `wb_flag` equal to `tx_stamp_req`.
- R4: A clock edge with `tx_sof` and `tx_stamp_req` both high loads `time_now` into `hold_stamp` and sets `ts_avail` after that edge.
- R5: Receive strobes, and transmit strobes with `tx_stamp_req` low, leave `hold_stamp`, `ts_avail` and `ts_overrun` unchanged.
- R6: `ts_avail` stays set until an edge with `clr_wr`=1 and `clr_data[0]`=1 clears it. If a flagged transmit capture happens at the same edge, the flag stays set.
- R7: A flagged transmit capture at an edge where `ts_avail` is 1 and is not being cleared sets `ts_overrun`. `ts_overrun` is cleared by an edge with `clr_wr`=1 and `clr_data[1]`=1, and a setting event at the same edge wins over the clear.
- R8: `wb_valid` is high in the cycle after a capture edge and stays high while any entry is pending. An entry is consumed at an edge with `wb_valid` and `wb_ready` both high. While `wb_valid` is high and `wb_ready` is low, `wb_stamp`, `wb_flag` and `wb_is_tx` hold their values.
- R9: Each path delivers its entries in capture order. When a new entry is chosen for presentation, a pending transmit entry is chosen ahead of a pending receive entry.
- R10: A strobe at an edge where its path already holds `DEPTH` entries (counted before any consumption at that edge) produces no entry. A flagged transmit strobe at such an edge still updates the holding register and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 32 | Local time counter value |
| tx_sof | input | 1 | Transmit delimiter detect strobe |
| tx_stamp_req | input | 1 | Timestamp request flag of the transmit frame, valid with `tx_sof` |
| rx_sof | input | 1 | Receive delimiter detect strobe |
| wb_valid | output | 1 | Writeback entry present |
| wb_ready | input | 1 | Writeback consumer accepts the entry |
| wb_stamp | output | 32 | Captured stamp of the presented entry |
| wb_flag | output | 1 | Status bit: request flag echo for transmit entries, 0 for receive entries |
| wb_is_tx | output | 1 | 1 for a transmit entry, 0 for a receive entry |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_data | input | 2 | Bit 0 clears `ts_avail`, bit 1 clears `ts_overrun` |
| hold_stamp | output | 32 | Last flagged transmit stamp |
| ts_avail | output | 1 | Sticky stamp-available interrupt flag |
| ts_overrun | output | 1 | Sticky overrun flag |

## Verification
The bench targets transmit and receive strobes that land on the same edge while the stream is stalled. A design that re-arbitrates during a stall would let a transmit entry replace a presented receive entry, so that entry's fields would change under a low `wb_ready`. The bench also places a clear and a flagged capture on the same edge. A design that lets the clear win would lose the availability flag, or would raise overrun for a stamp that software had already acknowledged. It fills a queue and keeps strobing, so it catches a design that overwrites an entry that is still pending. It also catches a design that lets a full queue block the holding register. Finally, it sends long runs of unflagged transmit and receive frames. A design that leaked those into the holding register or the flags would be seen there.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int TS_W = 32;

  typedef struct packed {
    logic [TS_W-1:0] stamp;
    logic            flag;
  } fsu_entry_t;
endpackage

// File: rtl/fsu_fifo.sv
module fsu_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  fsu_pkg::fsu_entry_t din,
  input  logic                pop,
  output fsu_pkg::fsu_entry_t dout,
  output logic                nonempty,
  output logic                full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  fsu_pkg::fsu_entry_t mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic do_push, do_pop;

  assign nonempty = (count != '0);
  assign full     = (count == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign dout     = mem[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/fsu_arb.sv
module fsu_arb (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tx_ne,
  input  logic                rx_ne,
  input  fsu_pkg::fsu_entry_t tx_head,
  input  fsu_pkg::fsu_entry_t rx_head,
  input  logic                ready,
  output logic                valid,
  output fsu_pkg::fsu_entry_t head,
  output logic                is_tx,
  output logic                tx_pop,
  output logic                rx_pop
);
  logic held, held_tx;

  assign valid  = tx_ne || rx_ne;
  assign is_tx  = held ? held_tx : tx_ne;
  assign head   = is_tx ? tx_head : rx_head;
  assign tx_pop = valid && ready && is_tx;
  assign rx_pop = valid && ready && !is_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held    <= 1'b0;
      held_tx <= 1'b0;
    end else begin
      held    <= valid && !ready;
      held_tx <= is_tx;
    end
  end
endmodule

// File: rtl/fsu_hold.sv
module fsu_hold #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [TS_W-1:0] time_now,
  input  logic            clr_wr,
  input  logic [1:0]      clr_data,
  output logic [TS_W-1:0] hold_stamp,
  output logic            ts_avail,
  output logic            ts_overrun
);
  logic clr_avail, clr_ovr, lost;

  assign clr_avail = clr_wr && clr_data[0];
  assign clr_ovr   = clr_wr && clr_data[1];
  assign lost      = capture && ts_avail && !clr_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_stamp <= '0;
      ts_avail   <= 1'b0;
      ts_overrun <= 1'b0;
    end else begin
      if (capture) hold_stamp <= time_now;
      if (capture)        ts_avail <= 1'b1;
      else if (clr_avail) ts_avail <= 1'b0;
      if (lost)         ts_overrun <= 1'b1;
      else if (clr_ovr) ts_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_stamp_unit.sv
module frame_stamp_unit #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [fsu_pkg::TS_W-1:0] time_now,
  input  logic                     tx_sof,
  input  logic                     tx_stamp_req,
  input  logic                     rx_sof,
  output logic                     wb_valid,
  input  logic                     wb_ready,
  output logic [fsu_pkg::TS_W-1:0] wb_stamp,
  output logic                     wb_flag,
  output logic                     wb_is_tx,
  input  logic                     clr_wr,
  input  logic [1:0]               clr_data,
  output logic [fsu_pkg::TS_W-1:0] hold_stamp,
  output logic                     ts_avail,
  output logic                     ts_overrun
);
  import fsu_pkg::*;

  localparam int NPATH = 2;

  fsu_entry_t in_ent [NPATH];
  fsu_entry_t q_head [NPATH];
  logic       q_push [NPATH];
  logic       q_pop  [NPATH];
  logic       q_ne   [NPATH];
  logic       q_full [NPATH];
  fsu_entry_t sel_ent;

  assign in_ent[0] = '{stamp: time_now, flag: tx_stamp_req};
  assign in_ent[1] = '{stamp: time_now, flag: 1'b0};
  assign q_push[0] = tx_sof;
  assign q_push[1] = rx_sof;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    fsu_fifo #(.DEPTH(DEPTH)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (q_push[g]),
      .din      (in_ent[g]),
      .pop      (q_pop[g]),
      .dout     (q_head[g]),
      .nonempty (q_ne[g]),
      .full     (q_full[g])
    );
  end

  fsu_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_ne   (q_ne[0]),
    .rx_ne   (q_ne[1]),
    .tx_head (q_head[0]),
    .rx_head (q_head[1]),
    .ready   (wb_ready),
    .valid   (wb_valid),
    .head    (sel_ent),
    .is_tx   (wb_is_tx),
    .tx_pop  (q_pop[0]),
    .rx_pop  (q_pop[1])
  );

  assign wb_stamp = sel_ent.stamp;
  assign wb_flag  = sel_ent.flag;

  fsu_hold #(.TS_W(TS_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (tx_sof && tx_stamp_req),
    .time_now   (time_now),
    .clr_wr     (clr_wr),
    .clr_data   (clr_data),
    .hold_stamp (hold_stamp),
    .ts_avail   (ts_avail),
    .ts_overrun (ts_overrun)
  );
endmodule

// File: rtl/fsu_checker.sv
module fsu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] time_now,
  input logic        tx_sof,
  input logic        tx_stamp_req,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic [31:0] wb_stamp,
  input logic        wb_flag,
  input logic        wb_is_tx,
  input logic        clr_wr,
  input logic [1:0]  clr_data,
  input logic [31:0] hold_stamp,
  input logic        ts_avail,
  input logic        ts_overrun
);
  a_r2_rx_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_is_tx |-> !wb_flag);

  a_r4_hold_loads: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof && tx_stamp_req |=> hold_stamp == $past(time_now) && ts_avail);

  a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_sof && tx_stamp_req) |=> $stable(hold_stamp));

  a_r6_avail_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_data[0] && !(tx_sof && tx_stamp_req) |=> !ts_avail);

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sof && tx_stamp_req && ts_avail && !(clr_wr && clr_data[0]) |=> ts_overrun);

  a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_stamp) && $stable(wb_flag) && $stable(wb_is_tx));
endmodule

bind frame_stamp_unit fsu_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .time_now     (time_now),
  .tx_sof       (tx_sof),
  .tx_stamp_req (tx_stamp_req),
  .wb_valid     (wb_valid),
  .wb_ready     (wb_ready),
  .wb_stamp     (wb_stamp),
  .wb_flag      (wb_flag),
  .wb_is_tx     (wb_is_tx),
  .clr_wr       (clr_wr),
  .clr_data     (clr_data),
  .hold_stamp   (hold_stamp),
  .ts_avail     (ts_avail),
  .ts_overrun   (ts_overrun)
);

// File: tb/frame_stamp_unit_test.sv
`timescale 1ns/1ps
module frame_stamp_unit_test;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] time_now = 32'h1000_0000;
  logic tx_sof = 0, tx_stamp_req = 0, rx_sof = 0, wb_ready = 0, clr_wr = 0;
  logic [1:0] clr_data = 0;
  logic wb_valid, wb_flag, wb_is_tx, ts_avail, ts_overrun;
  logic [31:0] wb_stamp, hold_stamp;

  always #10 clk = ~clk;

  frame_stamp_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_sof(tx_sof),
    .tx_stamp_req(tx_stamp_req), .rx_sof(rx_sof), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_stamp(wb_stamp), .wb_flag(wb_flag),
    .wb_is_tx(wb_is_tx), .clr_wr(clr_wr), .clr_data(clr_data),
    .hold_stamp(hold_stamp), .ts_avail(ts_avail), .ts_overrun(ts_overrun)
  );

  typedef struct { logic [31:0] s; logic f; } ent_t;
  ent_t txq[$];
  ent_t rxq[$];
  bit   m_held, m_held_tx, m_avail, m_ovr;
  logic [31:0] m_hold;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  // Reference model, advanced on each rising edge with the inputs held since the last one
  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_held = 0; m_held_tx = 0; m_avail = 0; m_ovr = 0; m_hold = 0;
    end else begin
      bit v, sel, txfull, rxfull, cap, clra;
      txfull = (txq.size() >= DEPTH);
      rxfull = (rxq.size() >= DEPTH);
      v   = (txq.size() + rxq.size()) > 0;
      sel = m_held ? m_held_tx : (txq.size() > 0);
      if (v && wb_ready) begin
        if (sel) void'(txq.pop_front()); else void'(rxq.pop_front());
      end
      m_held = v && !wb_ready;
      m_held_tx = sel;
      if (tx_sof && !txfull) txq.push_back('{s: time_now, f: tx_stamp_req});
      if (rx_sof && !rxfull) rxq.push_back('{s: time_now, f: 1'b0});
      cap  = tx_sof && tx_stamp_req;
      clra = clr_wr && clr_data[0];
      if (cap && m_avail && !clra) m_ovr = 1;
      else if (clr_wr && clr_data[1]) m_ovr = 0;
      if (cap) begin m_hold = time_now; m_avail = 1; end
      else if (clra) m_avail = 0;
    end
  end

  // Compare the design with the model between edges
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit v, sel;
      ent_t e;
      v = (txq.size() + rxq.size()) > 0;
      chk("R8 wb_valid", {31'b0, wb_valid}, {31'b0, v});
      if (v) begin
        sel = m_held ? m_held_tx : (txq.size() > 0);
        e = sel ? txq[0] : rxq[0];
        chk("R9 wb_is_tx", {31'b0, wb_is_tx}, {31'b0, sel});
        chk(sel ? "R3 wb_stamp" : "R2 wb_stamp", wb_stamp, e.s);
        chk(sel ? "R3 wb_flag" : "R2 wb_flag", {31'b0, wb_flag}, {31'b0, e.f});
      end
      chk("R4 hold_stamp", hold_stamp, m_hold);
      chk("R6 ts_avail", {31'b0, ts_avail}, {31'b0, m_avail});
      chk("R7 ts_overrun", {31'b0, ts_overrun}, {31'b0, m_ovr});
    end
  end

  task automatic cyc(input bit tx, input bit req, input bit rx,
                     input bit cw, input logic [1:0] cd, input bit rdy);
    @(posedge clk); #1;
    tx_sof = tx; tx_stamp_req = req; rx_sof = rx;
    clr_wr = cw; clr_data = cd; wb_ready = rdy;
    time_now = time_now + (($urandom % 5 == 0) ? 32'd2 : 32'd1);
  endtask

  task automatic drain();
    for (int i = 0; i < 4 * DEPTH + 4; i++) cyc(0, 0, 0, 0, 2'b00, 1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] h0;
    bit a0, o0;
    int seen;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 wb_valid", {31'b0, wb_valid}, 0);
    chk("R1 ts_avail", {31'b0, ts_avail}, 0);
    chk("R1 ts_overrun", {31'b0, ts_overrun}, 0);
    chk("R1 hold_stamp", hold_stamp, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R1 wb_valid after release", {31'b0, wb_valid}, 0);

    // R4 / R6 / R7: flagged captures, double capture, clear collision
    cyc(1, 1, 0, 0, 2'b00, 1);
    cyc(1, 1, 0, 0, 2'b00, 1);
    cyc(0, 0, 0, 1, 2'b10, 1);
    cyc(1, 1, 0, 1, 2'b01, 1);
    cyc(0, 0, 0, 0, 2'b00, 1);
    @(negedge clk);
    chk("R6 capture wins over clear", {31'b0, ts_avail}, 1);
    chk("R7 no overrun when cleared at same edge", {31'b0, ts_overrun}, 0);
    cyc(0, 0, 0, 1, 2'b01, 1);
    cyc(0, 0, 0, 0, 2'b00, 1);
    @(negedge clk);
    chk("R6 cleared", {31'b0, ts_avail}, 0);

    // R9: simultaneous strobes under stall, then release
    cyc(0, 0, 1, 0, 2'b00, 0);
    cyc(1, 0, 1, 0, 2'b00, 0);
    cyc(1, 1, 0, 0, 2'b00, 0);
    cyc(0, 0, 0, 0, 2'b00, 0);
    drain();

    // R5: unflagged traffic only
    cyc(1, 1, 0, 0, 2'b00, 1);
    cyc(0, 0, 0, 0, 2'b00, 1);
    @(negedge clk);
    h0 = hold_stamp; a0 = ts_avail; o0 = ts_overrun;
    for (int i = 0; i < 20; i++) cyc(i % 2 == 0, 0, i % 3 != 0, 0, 2'b00, i % 4 != 0);
    drain();
    @(negedge clk);
    chk("R5 hold_stamp unchanged", hold_stamp, h0);
    chk("R5 ts_avail unchanged", {31'b0, ts_avail}, {31'b0, a0});
    chk("R5 ts_overrun unchanged", {31'b0, ts_overrun}, {31'b0, o0});

    // R10: overfill the receive queue, flagged transmit into full transmit queue
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, i == DEPTH + 2, 1, 0, 2'b00, 0);
    cyc(0, 0, 0, 0, 2'b00, 0);
    @(negedge clk);
    chk("R10 hold updated while queue full", {31'b0, ts_avail}, 1);
    seen = 0;
    for (int i = 0; i < 4 * DEPTH; i++) begin
      cyc(0, 0, 0, 0, 2'b00, 1);
      @(negedge clk);
      if (wb_valid) seen++;
    end
    chk("R10 entries delivered", seen, 2 * DEPTH);

    // Mixed random traffic with back-pressure and clears
    for (int i = 0; i < 4000; i++)
      cyc($urandom % 3 == 0, $urandom % 2, $urandom % 3 == 0,
          $urandom % 6 == 0, 2'($urandom), $urandom % 3 != 0);
    drain();
    finish_run();
  end
endmodule